// File: doc/BRIEF.md
# Fibre Channel Signal Detect

This block decides, once per 160-bit interval, whether a usable Fibre Channel signal is arriving. It takes the recovered, aligned 10-bit characters of the link, one per `char_valid` strobe, together with two level flags from an external amplitude comparator. Three independent health states are kept: an amplitude state with hysteresis, a run-length state, and an ordered-set density counter. A single registered output, `sig_det`, is refreshed on the last character of every sixteen-character interval. It carries the health states as they stood when that character arrived.

The character input is a valid/ready stream whose ready is always high. The block never applies back-pressure: every cycle with `char_valid` high consumes `char_data`, and the source needs no other flow control. Ordered sets are framed by the comma character. A set counts as good if it equals the configurable `fill_pattern`, or if it is the third identical set in a row, which forms a primitive sequence. A good set repairs the run-length state and restarts the density count. Dropping `path_en` or `refclk_ok` turns the whole detector off.

Top module: `fc_sigdet`

## Requirements
- R1: `sig_det` changes only on the clock edge that takes the 16th accepted character of an interval, or when the detector is disabled. The value it takes reflects the health states held just before that character, so effects of the boundary character itself are reported one interval later.
- R2: On an interval boundary, `sig_det` becomes 1 only if all three hold: the amplitude state is good, the run-length state is good, and the density count is below 256.
- R3: Amplitude hysteresis works as follows. `amp_low` high makes the amplitude state bad on the next edge, and this wins when both flags are high. `amp_high` high alone makes it good. With both flags low the state holds.
- R4: Bits are examined with `char_data[9]` first and `char_data[0]` last. A run of 6 or more equal consecutive bits makes the run-length state bad until a good ordered set arrives. A violation in the same cycle as a good set leaves the state bad.
- R5: Runs continue across character boundaries. A run of four at the end of one character plus two at the start of the next is a violation; four plus one is not.
- R6: An ordered set is four characters that start with a comma (`10'b0011111010` or `10'b1100000101`). The first character sits in bits [39:30] of the assembled word. A set whose word equals `fill_pattern` is a good set, and a set that does not match has no effect.
- R7: Three back-to-back identical ordered sets form a primitive sequence, and the third is a good set. An accepted character outside a set breaks the sequence.
- R8: The density count clears on any good set. It increments on each interval boundary of an interval that saw no good set, and it saturates at 256. While the count is 256 the output reports loss of signal.
- R9: While `path_en` or `refclk_ok` is low, `sig_det` is 0 from the next edge on. All states return to reset values: amplitude bad, run length good, count 0, interval position 0. Characters presented meanwhile are ignored.
- R10: After reset `sig_det` is 0, and `char_ready` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| char_valid | input | 1 | A recovered character is present |
| char_ready | output | 1 | Always 1; the block never stalls |
| char_data | input | 10 | Recovered character, bit 9 received first |
| fill_pattern | input | 40 | Fill-word pattern, first character in [39:30] |
| amp_low | input | 1 | Input amplitude below the low threshold |
| amp_high | input | 1 | Input amplitude above the high threshold |
| path_en | input | 1 | Signal path routed through this detector |
| refclk_ok | input | 1 | Reference clock present |
| sig_det | output | 1 | Registered signal-detect result |

## Verification
The checks take for granted that every input is synchronous to `clk`. The amplitude flags are treated as levels that the comparator may assert at any time. `fill_pattern` is assumed to change only while no ordered set is being assembled. The bench drives every input on the falling edge and changes the fill pattern only between intervals. It keeps all data filler characters free of runs longer than two, so that only the deliberate violation characters disturb the run-length state.

// File: rtl/fc_sigdet_pkg.sv
package fc_sigdet_pkg;
  localparam int CHAR_W = 10;
  localparam logic [CHAR_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [CHAR_W-1:0] COMMA_POS = 10'b1100000101;

  function automatic logic is_comma(input logic [CHAR_W-1:0] c);
    return (c == COMMA_NEG) || (c == COMMA_POS);
  endfunction
endpackage

// File: rtl/fc_sigdet_amp.sv
module fc_sigdet_amp (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic lvl_low,
  input  logic lvl_high,
  output logic amp_good
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) amp_good <= 1'b0;
    else if (lvl_low)  amp_good <= 1'b0;
    else if (lvl_high) amp_good <= 1'b1;
  end
endmodule

// File: rtl/fc_sigdet_runlen.sv
module fc_sigdet_runlen
  import fc_sigdet_pkg::*;
#(
  parameter int RUN_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr,
  input  logic              good_set,
  output logic              rl_bad
);
  localparam int RW = $clog2(RUN_MAX + 2);
  localparam logic [RW-1:0] RUN_SAT = RW'(RUN_MAX + 1);

  logic          last_q, last_d;
  logic [RW-1:0] run_q, run_d;
  logic          viol;

  // serial walk over the character, first-received bit first
  always_comb begin
    last_d = last_q;
    run_d  = run_q;
    viol   = 1'b0;
    for (int i = CHAR_W - 1; i >= 0; i--) begin
      if (run_d != '0 && chr[i] == last_d) begin
        if (run_d != RUN_SAT) run_d = run_d + RW'(1);
      end else begin
        run_d = RW'(1);
      end
      last_d = chr[i];
      if (run_d > RW'(RUN_MAX)) viol = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      last_q <= 1'b0;
      run_q  <= '0;
      rl_bad <= 1'b0;
    end else begin
      if (chr_valid) begin
        last_q <= last_d;
        run_q  <= run_d;
      end
      if (chr_valid && viol) rl_bad <= 1'b1;
      else if (good_set)     rl_bad <= 1'b0;
    end
  end
endmodule

// File: rtl/fc_sigdet_oset.sv
module fc_sigdet_oset
  import fc_sigdet_pkg::*;
#(
  parameter int SET_CHARS   = 4,
  parameter int PRIM_REPEAT = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        chr_valid,
  input  logic [CHAR_W-1:0]           chr,
  input  logic [SET_CHARS*CHAR_W-1:0] fill_pattern,
  output logic                        good_set
);
  localparam int WW  = SET_CHARS * CHAR_W;
  localparam int PW  = $clog2(SET_CHARS);
  localparam int RPW = $clog2(PRIM_REPEAT + 1);
  localparam logic [PW-1:0]  LASTP  = PW'(SET_CHARS - 1);
  localparam logic [RPW-1:0] REPMAX = RPW'(PRIM_REPEAT);

  logic [CHAR_W-1:0] stash [SET_CHARS-1];
  logic [PW-1:0]     pos;
  logic [WW-1:0]     word, prev_word;
  logic [RPW-1:0]    rep, rep_next;
  logic              comma, fill_hit, prim_hit;

  genvar k;
  generate
    for (k = 0; k < SET_CHARS - 1; k++) begin : g_word
      assign word[(SET_CHARS-1-k)*CHAR_W +: CHAR_W] = stash[k];
    end
  endgenerate
  assign word[CHAR_W-1:0] = chr;

  assign comma    = is_comma(chr);
  assign fill_hit = (word == fill_pattern);

  always_comb begin
    if (rep != '0 && word == prev_word)
      rep_next = (rep == REPMAX) ? rep : rep + RPW'(1);
    else
      rep_next = RPW'(1);
  end
  assign prim_hit = (rep_next == REPMAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pos       <= '0;
      rep       <= '0;
      prev_word <= '0;
      good_set  <= 1'b0;
      for (int i = 0; i < SET_CHARS - 1; i++) stash[i] <= '0;
    end else begin
      good_set <= 1'b0;
      if (chr_valid) begin
        if (comma) begin
          stash[0] <= chr;
          pos      <= PW'(1);
        end else if (pos == '0) begin
          rep <= '0;
        end else if (pos == LASTP) begin
          pos       <= '0;
          prev_word <= word;
          rep       <= rep_next;
          good_set  <= fill_hit || prim_hit;
        end else begin
          for (int i = 1; i < SET_CHARS - 1; i++)
            if (pos == PW'(i)) stash[i] <= chr;
          pos <= pos + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fc_sigdet_density.sv
module fc_sigdet_density #(
  parameter int LIMIT = 256,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          good_set,
  input  logic          boundary,
  output logic [CW-1:0] cnt,
  output logic          dens_bad
);
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else begin
      if (good_set)
        cnt <= '0;
      else if (boundary && !seen && cnt != CW'(LIMIT))
        cnt <= cnt + CW'(1);
      if (boundary)      seen <= 1'b0;
      else if (good_set) seen <= 1'b1;
    end
  end

  assign dens_bad = (cnt >= CW'(LIMIT));
endmodule

// File: rtl/fc_sigdet.sv
module fc_sigdet
  import fc_sigdet_pkg::*;
#(
  parameter int SET_CHARS      = 4,
  parameter int PRIM_REPEAT    = 3,
  parameter int RUN_MAX        = 5,
  parameter int INTERVAL_CHARS = 16,
  parameter int DENS_LIMIT     = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        char_valid,
  output logic                        char_ready,
  input  logic [CHAR_W-1:0]           char_data,
  input  logic [SET_CHARS*CHAR_W-1:0] fill_pattern,
  input  logic                        amp_low,
  input  logic                        amp_high,
  input  logic                        path_en,
  input  logic                        refclk_ok,
  output logic                        sig_det
);
  localparam int IW = $clog2(INTERVAL_CHARS);
  localparam int CW = $clog2(DENS_LIMIT + 1);

  logic          enabled, take, interval_end;
  logic [IW-1:0] icnt;
  logic          amp_good, rl_bad, dens_bad, good_set;
  logic [CW-1:0] dens_cnt;

  assign char_ready   = 1'b1;
  assign enabled      = path_en && refclk_ok;
  assign take         = enabled && char_valid;
  assign interval_end = take && (icnt == IW'(INTERVAL_CHARS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !enabled) icnt <= '0;
    else if (take)          icnt <= interval_end ? '0 : icnt + IW'(1);
  end

  fc_sigdet_amp u_amp (
    .clk(clk), .rst_n(rst_n), .clr(!enabled),
    .lvl_low(amp_low), .lvl_high(amp_high), .amp_good(amp_good)
  );

  fc_sigdet_oset #(.SET_CHARS(SET_CHARS), .PRIM_REPEAT(PRIM_REPEAT)) u_oset (
    .clk(clk), .rst_n(rst_n), .clr(!enabled),
    .chr_valid(take), .chr(char_data),
    .fill_pattern(fill_pattern), .good_set(good_set)
  );

  fc_sigdet_runlen #(.RUN_MAX(RUN_MAX)) u_runlen (
    .clk(clk), .rst_n(rst_n), .clr(!enabled),
    .chr_valid(take), .chr(char_data),
    .good_set(good_set), .rl_bad(rl_bad)
  );

  fc_sigdet_density #(.LIMIT(DENS_LIMIT), .CW(CW)) u_dens (
    .clk(clk), .rst_n(rst_n), .clr(!enabled),
    .good_set(good_set), .boundary(interval_end),
    .cnt(dens_cnt), .dens_bad(dens_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !enabled) sig_det <= 1'b0;
    else if (interval_end)  sig_det <= amp_good && !rl_bad && !dens_bad;
  end
endmodule

// File: rtl/fc_sigdet_chk.sv
module fc_sigdet_chk #(
  parameter int DENS_LIMIT = 256,
  parameter int CW         = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          path_en,
  input logic          refclk_ok,
  input logic          amp_low,
  input logic          amp_high,
  input logic          sig_det,
  input logic          interval_end,
  input logic          amp_good,
  input logic          rl_bad,
  input logic          good_set,
  input logic [CW-1:0] dens_cnt
);
  assert_hold_between_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (path_en && refclk_ok && !interval_end) |=> $stable(sig_det));

  assert_rise_needs_amp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_det) |-> $past(amp_good));

  assert_rise_needs_runlen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_det) |-> $past(!rl_bad));

  assert_low_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (path_en && refclk_ok && amp_low) |=> !amp_good);

  assert_high_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (path_en && refclk_ok && amp_high && !amp_low) |=> amp_good);

  assert_set_clears_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (path_en && refclk_ok && good_set) |=> (dens_cnt == '0));

  assert_count_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dens_cnt <= CW'(DENS_LIMIT));

  assert_disabled_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(path_en && refclk_ok) |=> !sig_det);
endmodule

bind fc_sigdet fc_sigdet_chk #(.DENS_LIMIT(DENS_LIMIT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .path_en(path_en), .refclk_ok(refclk_ok),
  .amp_low(amp_low), .amp_high(amp_high), .sig_det(sig_det),
  .interval_end(interval_end), .amp_good(amp_good), .rl_bad(rl_bad),
  .good_set(good_set), .dens_cnt(dens_cnt)
);

// File: tb/fc_sigdet_test.sv
module fc_sigdet_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] K  = 10'b0011111010;
  localparam logic [9:0] D  = 10'b1010101010;
  localparam logic [9:0] X  = 10'b0110011001;
  localparam logic [39:0] FW  = {K, D, D, D};
  localparam logic [39:0] PSW = {K, X, X, X};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        char_valid = 1'b0;
  logic        char_ready;
  logic [9:0]  char_data = '0;
  logic [39:0] fill_pattern = FW;
  logic        amp_low = 1'b0, amp_high = 1'b0;
  logic        path_en = 1'b1, refclk_ok = 1'b1;
  logic        sig_det;

  int n_checks = 0, n_fail = 0, nchar = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_sigdet uut (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_ready(char_ready),
    .char_data(char_data), .fill_pattern(fill_pattern),
    .amp_low(amp_low), .amp_high(amp_high), .path_en(path_en),
    .refclk_ok(refclk_ok), .sig_det(sig_det)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic send(input logic [9:0] c);
    @(negedge clk);
    char_valid = 1'b1;
    char_data  = c;
    nchar++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      char_valid = 1'b0;
    end
  endtask

  task automatic send_set(input logic [39:0] w);
    for (int i = 3; i >= 0; i--) send(w[i*10 +: 10]);
  endtask

  // at least one filler, then filler up to the boundary, then settle
  task automatic finish_interval();
    send(D);
    while (nchar % 16 != 0) send(D);
    idle(1);
  endtask

  task automatic t_reset();
    check(sig_det, 1'b0, "R10 reset output");
    check(char_ready, 1'b1, "R10 ready");
  endtask

  task automatic t_link_up();
    amp_high = 1'b1;
    send_set(FW); idle(2); finish_interval();
    check(sig_det, 1'b1, "R2 healthy link");
    finish_interval();
    check(sig_det, 1'b1, "R2 healthy link second interval");
    check(char_ready, 1'b1, "R10 ready under traffic");
  endtask

  task automatic t_interval_amp();
    for (int i = 0; i < 4; i++) send(D);
    @(negedge clk); char_valid = 1'b0; amp_high = 1'b0; amp_low = 1'b1;
    @(negedge clk); amp_low = 1'b0;
    check(sig_det, 1'b1, "R1 no change mid interval");
    while (nchar % 16 != 15) send(D);
    idle(1);
    check(sig_det, 1'b1, "R1 no change before boundary char");
    send(D); idle(1);
    check(sig_det, 1'b0, "R1 update on boundary");
    finish_interval();
    check(sig_det, 1'b0, "R3 bad state holds");
    @(negedge clk); amp_high = 1'b1;
    @(negedge clk); amp_high = 1'b0;
    finish_interval();
    check(sig_det, 1'b1, "R3 good state holds");
    @(negedge clk); amp_high = 1'b1; amp_low = 1'b1;
    @(negedge clk); amp_high = 1'b0; amp_low = 1'b0;
    finish_interval();
    check(sig_det, 1'b0, "R3 low wins over high");
    amp_high = 1'b1;
    finish_interval();
    check(sig_det, 1'b1, "R3 recover");
  endtask

  task automatic t_runlen();
    send(10'b1111110000);
    finish_interval();
    check(sig_det, 1'b0, "R4 run of six");
    finish_interval();
    check(sig_det, 1'b0, "R4 stays bad");
    send_set(FW); idle(2); finish_interval();
    check(sig_det, 1'b1, "R4 cleared by fill word");
    send(10'b1010101111); send(10'b1101010101);
    finish_interval();
    check(sig_det, 1'b0, "R5 run spans characters");
    send_set(FW); idle(2); finish_interval();
    send(10'b1010101111); send(D);
    finish_interval();
    check(sig_det, 1'b1, "R5 run of five across boundary ok");
  endtask

  task automatic t_sets();
    send(10'b1111110000);
    send_set(PSW); send_set(PSW); idle(2); finish_interval();
    check(sig_det, 1'b0, "R7 two repeats not a sequence");
    send_set(PSW); send_set(PSW); send_set(PSW); idle(2); finish_interval();
    check(sig_det, 1'b1, "R7 three repeats clear");
    fill_pattern = PSW;
    send(10'b1111110000);
    send_set(FW); idle(2); finish_interval();
    check(sig_det, 1'b0, "R6 non-matching set ignored");
    send_set(PSW); idle(2); finish_interval();
    check(sig_det, 1'b1, "R6 configured pattern clears");
    fill_pattern = FW;
  endtask

  task automatic t_density();
    send_set(FW); idle(2); finish_interval();
    for (int j = 0; j < 256; j++) finish_interval();
    check(sig_det, 1'b1, "R8 count 255 still good");
    finish_interval();
    check(sig_det, 1'b0, "R8 count reaches 256");
    for (int j = 0; j < 3; j++) finish_interval();
    check(sig_det, 1'b0, "R8 saturated stays bad");
    send_set(FW); idle(2); finish_interval();
    check(sig_det, 1'b1, "R8 cleared by fill word");
  endtask

  task automatic t_disable();
    for (int i = 0; i < 5; i++) send(D);
    @(negedge clk); char_valid = 1'b0; path_en = 1'b0;
    @(negedge clk);
    check(sig_det, 1'b0, "R9 path disabled");
    send(10'b1111110000); send(D); idle(1);
    path_en = 1'b1; nchar = 0;
    @(negedge clk);
    for (int i = 0; i < 15; i++) send(D);
    idle(1);
    check(sig_det, 1'b0, "R9 interval restarts");
    send(D); idle(1);
    check(sig_det, 1'b1, "R9 disabled chars ignored");
    @(negedge clk); refclk_ok = 1'b0;
    @(negedge clk);
    check(sig_det, 1'b0, "R9 reference clock missing");
    refclk_ok = 1'b1; nchar = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_link_up();
    t_interval_amp();
    t_runlen();
    t_sets();
    t_density();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 run did not complete: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule